// File: doc/BRIEF.md
# Single-Cycle Barrel Shifter with Count Modes

This block shifts or rotates a 32-bit operand by a 6-bit count. There are four operations: logical left, logical right, arithmetic right and rotate right. A log-depth network does any shift distance in one compute stage, and it works on a 64-bit funnel word. In that word the upper half carries the bits that fill in from the left. A per-operation mode input selects how counts of 32 or more are treated:

- **Wrap mode** keeps only the low five count bits.
- **Saturating mode** treats a count that reaches the operand width as pushing every bit out.

Operations enter through a valid/ready handshake, one per clock. Each operation goes through three registers: input capture, compute and output. Results leave in the order the operations arrived. The block also reports a carry: the last bit shifted out. When an operation moves no bits, the carry keeps the value left by the operation before it in issue order.

Top module: `shift_unit`

## Requirements
- R1: After reset `outValid` and `outCarry` are 0.
- R2: Op code 0 (logical left) by effective count n gives `inData << n`. For n of at least 1, the carry is `inData[32-n]`.
- R3: Op code 1 (logical right) by n gives `inData >> n` with zeros filled in. For n of at least 1, the carry is `inData[n-1]`.
- R4: Op code 2 (arithmetic right) by n fills copies of `inData[31]` from the left. For n of at least 1, the carry is `inData[n-1]`.
- R5: Op code 3 (rotate right) always uses the count modulo 32, in both modes. For a nonzero effective count, the carry equals result bit 31.
- R6: When `inMode` = 0 (wrap), a count from 32 to 63 acts as the count minus 32 for every operation.
- R7: When `inMode` = 1 (saturating), a logical shift with a count of at least 32 gives 0 with carry 0.
- R8: When `inMode` = 1, an arithmetic right shift with a count of at least 32 gives 32 copies of `inData[31]`, and the carry equals `inData[31]`.
- R9: An operation with effective count 0 returns `inData` unchanged and leaves the carry at the value of the previous operation in order. This does not apply to a saturated shift.
- R10: An operation accepted at a clock edge appears on `outValid`/`outData` after the second edge that follows it, provided the output is not stalled. Results come out in acceptance order, one per clock.
- R11: While `outValid` is 1 and `outReady` is 0, `outData`, `outCarry` and `outValid` hold, and `inReady` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Operation offered |
| inReady | output | 1 | Operation taken at this edge when high with inValid |
| inData | input | 32 | Operand |
| inCount | input | 6 | Shift or rotate distance |
| inOp | input | 2 | 0 left logical, 1 right logical, 2 right arithmetic, 3 rotate right |
| inMode | input | 1 | 0 wrap the count to five bits, 1 saturate at width |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Consumer takes the result |
| outData | output | 32 | Shifted result |
| outCarry | output | 1 | Last bit shifted out |

## Verification
Two things can meet in the same cycle: the carry-hold rule for a zero-distance operation and a stall of the output. A held carry has to survive both the operation before it being stalled and the pipeline advancing again. The bench creates this by sending back-to-back streams that mix zero, 32 and 63 counts in both modes while `outReady` is dropped at random. A queue-style reference model runs in the bench. It tracks the carry in issue order and the expected contents of each stage, and every clock it compares the result, the carry, `outValid` and `inReady` against that model.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [1:0] {
    OpShl = 2'd0,
    OpShr = 2'd1,
    OpSar = 2'd2,
    OpRor = 2'd3
  } shOpE;

  typedef struct packed {
    logic adv;       // whole pipe moves one step
    logic carryUpd;  // compute stage holds a live op this step
  } shCtlS;
endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shift_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  inValid,
  output logic  inReady,
  input  logic  outReady,
  output logic  outValid,
  output shCtlS ctl
);
  logic v1, v2, v3;
  logic adv;

  assign adv = !v3 || outReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else if (adv) begin
      v1 <= inValid;
      v2 <= v1;
      v3 <= v2;
    end
  end

  assign inReady      = adv;
  assign outValid     = v3;
  assign ctl.adv      = adv;
  assign ctl.carryUpd = adv && v1;
endmodule

// File: rtl/shift_dp.sv
module shift_dp
  import shift_pkg::*;
#(
  parameter int DataW      = 32,
  parameter int CountW     = 6,
  parameter bit SatAllBits = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  shCtlS             ctl,
  input  logic [DataW-1:0]  inData,
  input  logic [CountW-1:0] inCount,
  input  logic [1:0]        inOp,
  input  logic              inMode,
  output logic [DataW-1:0]  outData,
  output logic              outCarry
);
  localparam int StageN = $clog2(DataW);
  localparam int FunW   = 2 * DataW;

  // stage 1: captured operands
  logic [DataW-1:0]  aQ;
  logic [CountW-1:0] cntQ;
  shOpE              opQ;
  logic              modeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aQ    <= '0;
      cntQ  <= '0;
      opQ   <= OpShl;
      modeQ <= 1'b0;
    end else if (ctl.adv) begin
      aQ    <= inData;
      cntQ  <= inCount;
      opQ   <= shOpE'(inOp);
      modeQ <= inMode;
    end
  end

  // count decode
  logic [StageN-1:0] effN;
  logic              overBig;
  logic              satHit;

  assign effN = cntQ[StageN-1:0];

  generate
    if (SatAllBits) begin : g_satAll
      assign overBig = |cntQ[CountW-1:StageN];
    end else begin : g_satOne
      assign overBig = cntQ[StageN];
    end
  endgenerate

  assign satHit = modeQ && overBig && (opQ != OpRor);

  // funnel operands; left shift is a right shift of the mirrored word
  logic [DataW-1:0] aRev;
  logic [DataW-1:0] loIn;
  logic [DataW-1:0] hiIn;

  generate
    for (genvar i = 0; i < DataW; i++) begin : g_rev
      assign aRev[i] = aQ[DataW-1-i];
    end
  endgenerate

  always_comb begin
    loIn = (opQ == OpShl) ? aRev : aQ;
    unique case (opQ)
      OpSar:   hiIn = {DataW{aQ[DataW-1]}};
      OpRor:   hiIn = aQ;
      default: hiIn = '0;
    endcase
  end

  // log-depth network
  logic [FunW-1:0] stg [0:StageN];
  assign stg[0] = {hiIn, loIn};

  generate
    for (genvar k = 0; k < StageN; k++) begin : g_stage
      localparam int Dist = 2 ** k;
      assign stg[k+1] = effN[k] ? (stg[k] >> Dist) : stg[k];
    end
  endgenerate

  logic [DataW-1:0] funOut;
  logic [DataW-1:0] funRev;
  assign funOut = stg[StageN][DataW-1:0];

  generate
    for (genvar i = 0; i < DataW; i++) begin : g_unrev
      assign funRev[i] = funOut[DataW-1-i];
    end
  endgenerate

  // result and carry selection
  logic             carryState;
  logic [DataW-1:0] resNext;
  logic             carryNext;
  logic             lastOut;

  assign lastOut = loIn[effN - StageN'(1)];

  always_comb begin
    if (satHit) begin
      resNext   = (opQ == OpSar) ? {DataW{aQ[DataW-1]}} : '0;
      carryNext = (opQ == OpSar) ? aQ[DataW-1] : 1'b0;
    end else begin
      resNext   = (opQ == OpShl) ? funRev : funOut;
      carryNext = (effN == '0) ? carryState : lastOut;
    end
  end

  // stage 2: computed result
  logic [DataW-1:0] resQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resQ       <= '0;
      carryState <= 1'b0;
    end else begin
      if (ctl.adv)      resQ       <= resNext;
      if (ctl.carryUpd) carryState <= carryNext;
    end
  end

  // stage 3: output register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData  <= '0;
      outCarry <= 1'b0;
    end else if (ctl.adv) begin
      outData  <= resQ;
      outCarry <= carryState;
    end
  end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_pkg::*;
#(
  parameter int DataW      = 32,
  parameter int CountW     = 6,
  parameter bit SatAllBits = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DataW-1:0]  inData,
  input  logic [CountW-1:0] inCount,
  input  logic [1:0]        inOp,
  input  logic              inMode,
  output logic              outValid,
  input  logic              outReady,
  output logic [DataW-1:0]  outData,
  output logic              outCarry
);
  shCtlS ctl;

  shift_ctrl ctrlI (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .outReady (outReady),
    .outValid (outValid),
    .ctl      (ctl)
  );

  shift_dp #(
    .DataW      (DataW),
    .CountW     (CountW),
    .SatAllBits (SatAllBits)
  ) dpI (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .inData   (inData),
    .inCount  (inCount),
    .inOp     (inOp),
    .inMode   (inMode),
    .outData  (outData),
    .outCarry (outCarry)
  );
endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk #(
  parameter int DataW  = 32,
  parameter int CountW = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic [DataW-1:0]  inData,
  input logic [CountW-1:0] inCount,
  input logic [1:0]        inOp,
  input logic              inMode,
  input logic              outValid,
  input logic              outReady,
  input logic [DataW-1:0]  outData,
  input logic              outCarry
);
  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outCarry));

  // R11
  stall_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |-> !inReady);

  // R10
  fixed_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) ##1 inReady ##1 inReady |=> outValid);

  // R7
  sat_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inMode && inCount[5] && inOp[1] == 1'b0) ##1 inReady ##1 inReady
      |=> outData == '0 && !outCarry);

  // R6
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !inMode && inCount[4:0] == 5'd0) ##1 inReady ##1 inReady
      |=> outData == $past(inData, 3));

  // R5
  rot_keep_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inOp == 2'd3) ##1 inReady ##1 inReady
      |=> $countones(outData) == $countones($past(inData, 3)));
endmodule

bind shift_unit shift_unit_chk #(.DataW(DataW), .CountW(CountW)) chkI (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .inData   (inData),
  .inCount  (inCount),
  .inOp     (inOp),
  .inMode   (inMode),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData),
  .outCarry (outCarry)
);

// File: tb/tb_shift_unit.sv
`timescale 1ns/1ps
module tb_shift_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inData = '0;
  logic [5:0]  inCount = '0;
  logic [1:0]  inOp = '0;
  logic        inMode = 1'b0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [31:0] outData;
  logic        outCarry;

  always #10 clk = ~clk;

  shift_unit dut (.*);

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit randReady = 1'b0;
  bit done = 1'b0;

  // model state
  bit          modelCarry = 1'b0;
  bit          mv [3];
  logic [31:0] md [3];
  bit          mc [3];
  string       mt [3];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic void refOp(input logic [31:0] a, input logic [5:0] c, input logic [1:0] op,
                                input bit m, output logic [31:0] r, output string tag);
    int n;
    bit sat;
    n = c % 32;
    sat = m && (c >= 32) && (op != 2'd3);
    if (sat) begin
      if (op == 2'd2) begin
        r = {32{a[31]}}; modelCarry = a[31]; tag = "R8";
      end else begin
        r = 32'd0; modelCarry = 1'b0; tag = "R7";
      end
      return;
    end
    case (op)
      2'd0: r = a << n;
      2'd1: r = a >> n;
      2'd2: r = 32'($signed(a) >>> n);
      default: r = (n == 0) ? a : ((a >> n) | (a << (32 - n)));
    endcase
    if (n != 0) modelCarry = (op == 2'd0) ? a[32-n] : a[n-1];
    if (op == 2'd3) tag = "R5";
    else if (n == 0) tag = "R9";
    else if (c >= 32) tag = "R6";
    else if (op == 2'd0) tag = "R2";
    else if (op == 2'd1) tag = "R3";
    else tag = "R4";
  endfunction

  // reference pipeline: compare at falling edge, then step for the next rising edge
  always @(negedge clk) begin
    if (rstN) begin
      bit adv;
      chk(outValid == mv[2], "R10 valid", 32'(outValid), 32'(mv[2]));
      if (mv[2]) begin
        chk(outData == md[2], {mt[2], " data"}, outData, md[2]);
        chk(outCarry == mc[2], {mt[2], " carry"}, 32'(outCarry), 32'(mc[2]));
      end
      adv = !mv[2] || outReady;
      chk(inReady == adv, "R11 ready", 32'(inReady), 32'(adv));
      if (adv) begin
        mv[2] = mv[1]; md[2] = md[1]; mc[2] = mc[1]; mt[2] = mt[1];
        mv[1] = mv[0]; md[1] = md[0]; mc[1] = mc[0]; mt[1] = mt[0];
        mv[0] = inValid;
        if (inValid) begin
          logic [31:0] r;
          string tg;
          refOp(inData, inCount, inOp, inMode, r, tg);
          md[0] = r; mc[0] = modelCarry; mt[0] = tg;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(posedge clk) begin
    #2;
    if (randReady) outReady = ($urandom % 4) != 0;
  end

  task automatic sendOp(input logic [31:0] a, input logic [5:0] c, input logic [1:0] op, input bit m);
    bit acc;
    inValid = 1'b1; inData = a; inCount = c; inOp = op; inMode = m;
    do begin
      @(negedge clk);
      acc = inReady;
      @(posedge clk);
      #2;
    end while (!acc);
    inValid = 1'b0;
  endtask

  initial begin
    int cnts [6] = '{0, 1, 31, 32, 33, 63};
    for (int i = 0; i < 3; i++) mv[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(outValid == 1'b0, "R1 valid", 32'(outValid), 32'd0);
    chk(outCarry == 1'b0, "R1 carry", 32'(outCarry), 32'd0);
    @(posedge clk);
    #2 rstN = 1'b1;

    // directed sweep, no stalls: every op, corner counts, both modes
    foreach (cnts[j]) begin
      for (int op = 0; op < 4; op++) begin
        for (int m = 0; m < 2; m++) begin
          sendOp(32'h8000_0001 ^ (32'h1234_5678 * (j + 1)), 6'(cnts[j]), 2'(op), 1'(m));
          sendOp(32'h7F00_A5C3, 6'(cnts[j]), 2'(op), 1'(m));
        end
      end
    end

    // zero-distance carry holds behind stalls (R9 with R11)
    randReady = 1'b1;
    for (int i = 0; i < 400; i++) begin
      logic [5:0] c;
      c = (i % 3 == 0) ? 6'(32 * ($urandom % 2)) : 6'($urandom);
      sendOp($urandom, c, 2'($urandom), 1'($urandom));
    end

    // random back-to-back stream with random back-pressure
    for (int i = 0; i < 3000; i++) begin
      inValid = ($urandom % 5) != 0;
      if (inValid) sendOp($urandom, 6'($urandom), 2'($urandom), 1'($urandom));
      else begin
        @(posedge clk);
        #2;
      end
    end

    randReady = 1'b0;
    outReady = 1'b1;
    inValid = 1'b0;
    repeat (10) @(posedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule